// File: doc/BRIEF.md
# I2C Clock Phase Generator with Selectable Duty Ratio

This block produces the clock line waveform of an I2C master from a fast reference clock. A programmable prescaler turns the reference clock into ratio units, with each unit lasting `divider + 1` reference cycles. A two-bit ratio select chooses how many units the clock stays low and how many it stays high. The duty cycle is therefore one of a few fixed uneven splits instead of a plain half-and-half square wave. The line is driven open-drain: the block only ever pulls it low or lets it go.

The high phase counts only on cycles where the sensed line actually reads high. A slave that holds the line low after the master has let go therefore stretches the period. Besides the drive enable, the block gives a byte engine four single-cycle phase strobes: the falling edge, the rising edge, the middle of the low phase (the point to change the data line) and the middle of the high phase (the point to sample it). The ratio and divider are captured at the start of every low phase, so a new setting applies cleanly from the next full period.

Top module: `scl_duty_gen`

## Requirements
- R1: While `rstN` is low, and in every cycle that follows a cycle with `enable` low, `sclDriveLow` and all four strobes are 0.
- R2: In the cycle after `enable` is first seen high, the low phase starts. `sclDriveLow` is then 1 for exactly Nlow·(divider+1) consecutive cycles. After that it is 0 for the whole high phase.
- R3: `ratioSel` = 0 gives Nlow = 4 and Nhigh = 4 units.
- R4: `ratioSel` = 1 gives Nlow = 6 and Nhigh = 3 units.
- R5: `ratioSel` = 2 gives Nlow = 11 and Nhigh = 3 units.
- R6: `ratioSel` = 3 behaves exactly like `ratioSel` = 0.
- R7: The high phase ends after Nhigh·(divider+1) cycles in which `sclIn` was high. Cycles with `sclIn` low do not count. When the high phase ends, the next low phase starts at once.
- R8: `sclFall` is 1 only in the first cycle of each low phase. `sclRise` is 1 only in the first cycle of the high phase in which `sclIn` reads high.
- R9: `sclMidLow` is 1 in the low-phase cycle with floor(Nlow/2)·(divider+1) earlier low cycles. `sclMidHigh` is 1 in the first counting high-phase cycle with floor(Nhigh/2)·(divider+1) earlier counted high cycles. At most one strobe is 1 in any cycle.
- R10: `ratioSel` and `divider` are sampled only at the edge that starts a low phase. Changes at other times take effect from the next period.
- R11: Dropping `enable` in any phase releases the line in the next cycle and clears all counters. Re-enabling starts a full low phase from the beginning.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run the clock generator; low releases the line and clears counters |
| ratioSel | input | 2 | Low-to-high unit ratio: 0 = 4:4, 1 = 6:3, 2 = 11:3, 3 = as 0 |
| divider | input | DIV_W | Reference cycles per ratio unit, minus one |
| sclIn | input | 1 | Sensed level of the clock line |
| sclDriveLow | output | 1 | 1 pulls the clock line low; 0 releases it |
| sclRise | output | 1 | Strobe: first counting cycle of the high phase |
| sclFall | output | 1 | Strobe: first cycle of the low phase |
| sclMidHigh | output | 1 | Strobe: middle of the high phase (sample point) |
| sclMidLow | output | 1 | Strobe: middle of the low phase (data change point) |

## Verification
All outputs decode the registered phase and counters. A change of `enable`, `ratioSel` or `divider` therefore shows up one clock after the edge that samples it. A level on `sclIn` gates `sclRise` and `sclMidHigh` in the same cycle, and it gates the counter advance at the next edge. The bench drives inputs just after a rising edge and compares every output at the falling edge against a behavioural model whose state covers the cycles before that edge. Only after the comparison does the model step, using the same input values the design samples at the following edge. Stretching is produced by a modelled slave that pulls the wired-AND line low on chosen cycles.

// File: rtl/scl_duty_pkg.sv
package scl_duty_pkg;

  localparam int UNIT_W = 4;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_e;

  // control -> counter datapath
  typedef struct packed {
    logic clear;
    logic load;
    logic step;
    logic highSel;
  } cnt_ctl_t;

  // counter datapath -> control
  typedef struct packed {
    logic phaseEnd;
    logic atStart;
    logic atMid;
  } cnt_sts_t;

  function automatic logic [UNIT_W-1:0] lowUnits(input logic [1:0] sel);
    case (sel)
      2'd1:    lowUnits = UNIT_W'(6);
      2'd2:    lowUnits = UNIT_W'(11);
      default: lowUnits = UNIT_W'(4);
    endcase
  endfunction

  function automatic logic [UNIT_W-1:0] highUnits(input logic [1:0] sel);
    case (sel)
      2'd1, 2'd2: highUnits = UNIT_W'(3);
      default:    highUnits = UNIT_W'(4);
    endcase
  endfunction

endpackage

// File: rtl/scl_unit_counter.sv
module scl_unit_counter
  import scl_duty_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  cnt_ctl_t         ctl,
  input  logic [1:0]       ratioSel,
  input  logic [DIV_W-1:0] divider,
  output cnt_sts_t         sts
);

  logic [DIV_W-1:0]  divQ;
  logic [1:0]        ratioQ;
  logic [DIV_W-1:0]  tickQ;
  logic [UNIT_W-1:0] unitQ;
  logic [UNIT_W-1:0] nUnits;
  logic              tickWrap;
  logic              lastUnit;

  assign nUnits   = ctl.highSel ? highUnits(ratioQ) : lowUnits(ratioQ);
  assign tickWrap = (tickQ == divQ);
  assign lastUnit = (unitQ == nUnits - UNIT_W'(1));

  assign sts.phaseEnd = ctl.step & tickWrap & lastUnit;
  assign sts.atStart  = (tickQ == '0) && (unitQ == '0);
  assign sts.atMid    = (tickQ == '0) && (unitQ == (nUnits >> 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divQ   <= '0;
      ratioQ <= 2'd0;
      tickQ  <= '0;
      unitQ  <= '0;
    end else begin
      if (ctl.load) begin
        divQ   <= divider;
        ratioQ <= ratioSel;
      end
      if (ctl.clear) begin
        tickQ <= '0;
        unitQ <= '0;
      end else if (ctl.step) begin
        if (tickWrap) begin
          tickQ <= '0;
          unitQ <= lastUnit ? '0 : unitQ + UNIT_W'(1);
        end else begin
          tickQ <= tickQ + DIV_W'(1);
        end
      end
    end
  end

  AST_TICK_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    tickQ <= divQ); // R2

  AST_UNIT_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    unitQ < nUnits); // R3

  AST_CFG_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.load |=> ($stable(divQ) && $stable(ratioQ))); // R10

  AST_RESERVED_AS_STD: assert property (@(posedge clk) disable iff (!rstN)
    (ratioQ == 2'd3) |-> (nUnits == UNIT_W'(4))); // R6

endmodule

// File: rtl/scl_phase_ctl.sv
module scl_phase_ctl
  import scl_duty_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     enable,
  input  logic     sclIn,
  input  cnt_sts_t sts,
  output cnt_ctl_t ctl,
  output logic     driveLow,
  output logic     riseStb,
  output logic     fallStb,
  output logic     midHighStb,
  output logic     midLowStb
);

  phase_e phaseQ;
  phase_e phaseNext;

  always_comb begin
    ctl         = '0;
    ctl.highSel = (phaseQ == PH_HIGH);
    phaseNext   = phaseQ;
    if (!enable) begin
      ctl.clear = 1'b1;
      phaseNext = PH_IDLE;
    end else begin
      case (phaseQ)
        PH_IDLE: begin
          ctl.clear = 1'b1;
          ctl.load  = 1'b1;
          phaseNext = PH_LOW;
        end
        PH_LOW: begin
          ctl.step = 1'b1;
          if (sts.phaseEnd) phaseNext = PH_HIGH;
        end
        PH_HIGH: begin
          ctl.step = sclIn;
          if (sts.phaseEnd) begin
            phaseNext = PH_LOW;
            ctl.load  = 1'b1;
          end
        end
        default: begin
          ctl.clear = 1'b1;
          phaseNext = PH_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) phaseQ <= PH_IDLE;
    else       phaseQ <= phaseNext;
  end

  assign driveLow   = (phaseQ == PH_LOW);
  assign fallStb    = (phaseQ == PH_LOW) && sts.atStart;
  assign midLowStb  = (phaseQ == PH_LOW) && sts.atMid;
  assign riseStb    = (phaseQ == PH_HIGH) && sclIn && sts.atStart;
  assign midHighStb = (phaseQ == PH_HIGH) && sclIn && sts.atMid;

  AST_RELEASE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!driveLow && (phaseQ == PH_IDLE))); // R11

  AST_STRETCH_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (enable && (phaseQ == PH_HIGH) && !sclIn) |=> (phaseQ == PH_HIGH)); // R7

  AST_FALL_ON_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(driveLow) |-> fallStb); // R8

  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({riseStb, fallStb, midHighStb, midLowStb})); // R9

  AST_LOW_FOLLOWS_START: assert property (@(posedge clk) disable iff (!rstN)
    (enable && (phaseQ == PH_IDLE)) |=> driveLow); // R2

endmodule

// File: rtl/scl_duty_gen.sv
module scl_duty_gen
  import scl_duty_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [1:0]       ratioSel,
  input  logic [DIV_W-1:0] divider,
  input  logic             sclIn,
  output logic             sclDriveLow,
  output logic             sclRise,
  output logic             sclFall,
  output logic             sclMidHigh,
  output logic             sclMidLow
);

  cnt_ctl_t cntCtl;
  cnt_sts_t cntSts;

  scl_phase_ctl u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (enable),
    .sclIn      (sclIn),
    .sts        (cntSts),
    .ctl        (cntCtl),
    .driveLow   (sclDriveLow),
    .riseStb    (sclRise),
    .fallStb    (sclFall),
    .midHighStb (sclMidHigh),
    .midLowStb  (sclMidLow)
  );

  scl_unit_counter #(.DIV_W(DIV_W)) u_cnt (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (cntCtl),
    .ratioSel (ratioSel),
    .divider  (divider),
    .sts      (cntSts)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |=> (!sclDriveLow && !sclFall && !sclMidLow)); // R1

endmodule

// File: tb/sim_scl_duty_gen.sv
module sim_scl_duty_gen;

  localparam int CLK_PERIOD = 10;
  localparam int DIV_W      = 8;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             enable = 1'b0;
  logic [1:0]       ratioSel = 2'd0;
  logic [DIV_W-1:0] divider = '0;
  logic             slaveHold = 1'b0;
  logic             sclIn;
  logic             sclDriveLow, sclRise, sclFall, sclMidHigh, sclMidLow;

  int    checks = 0;
  int    fails  = 0;
  int    cycles = 0;
  string curReq = "R1";
  bit    done   = 1'b0;

  // wired-AND line: master pull or slave hold
  assign sclIn = ~sclDriveLow & ~slaveHold;

  always #(CLK_PERIOD/2) clk = ~clk;

  scl_duty_gen #(.DIV_W(DIV_W)) u0 (
    .clk(clk), .rstN(rstN), .enable(enable), .ratioSel(ratioSel),
    .divider(divider), .sclIn(sclIn), .sclDriveLow(sclDriveLow),
    .sclRise(sclRise), .sclFall(sclFall), .sclMidHigh(sclMidHigh),
    .sclMidLow(sclMidLow)
  );

  // reference model state
  int mPhase = 0;   // 0 off, 1 low, 2 high
  int mCnt   = 0;   // counted cycles so far in this phase
  int mLowU  = 4, mHighU = 4, mDiv = 0;

  function automatic int unitsOf(input int sel, input bit high);
    if (sel == 1) return high ? 3 : 6;
    if (sel == 2) return high ? 3 : 11;
    return 4;
  endfunction

  task automatic check1(input string req, input string what, input bit act, input bit exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s at cycle %0d: actual %0b expected %0b", req, what, cycles, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (!rstN) begin
      check1("R1", "sclDriveLow in reset", sclDriveLow, 1'b0);
      check1("R1", "sclFall in reset", sclFall, 1'b0);
      mPhase = 0; mCnt = 0;
    end else begin
      int span;
      span = (mPhase == 2 ? mHighU : mLowU) * (mDiv + 1);
      check1(curReq, "sclDriveLow", sclDriveLow, mPhase == 1);
      check1("R8", "sclFall", sclFall, mPhase == 1 && mCnt == 0);
      check1("R8", "sclRise", sclRise, mPhase == 2 && sclIn && mCnt == 0);
      check1("R9", "sclMidLow", sclMidLow, mPhase == 1 && mCnt == (mLowU/2)*(mDiv+1));
      check1("R9", "sclMidHigh", sclMidHigh,
             mPhase == 2 && sclIn && mCnt == (mHighU/2)*(mDiv+1));
      // advance model with the inputs the design samples at the next edge
      if (!enable) begin
        mPhase = 0; mCnt = 0;
      end else if (mPhase == 0) begin
        mPhase = 1; mCnt = 0;
        mLowU = unitsOf(ratioSel, 0); mHighU = unitsOf(ratioSel, 1); mDiv = divider;
      end else if (mPhase == 1) begin
        mCnt++;
        if (mCnt == span) begin mPhase = 2; mCnt = 0; end
      end else if (sclIn) begin
        mCnt++;
        if (mCnt == span) begin
          mPhase = 1; mCnt = 0;
          mLowU = unitsOf(ratioSel, 0); mHighU = unitsOf(ratioSel, 1); mDiv = divider;
        end
      end
    end
  end

  task automatic runCycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    int lowRun;
    runCycles(4);
    rstN = 1'b1;
    runCycles(3);
    curReq = "R1";                       // disabled: line released
    runCycles(5);

    curReq = "R3"; ratioSel = 2'd0; divider = 8'd2; enable = 1'b1;
    runCycles(80);
    curReq = "R11"; enable = 1'b0; runCycles(4);

    curReq = "R4"; ratioSel = 2'd1; divider = 8'd1; enable = 1'b1;
    runCycles(60);
    enable = 1'b0; runCycles(3);

    curReq = "R5"; ratioSel = 2'd2; divider = 8'd0; enable = 1'b1;
    runCycles(50);
    enable = 1'b0; runCycles(2);
    // directed R2/R5: low run length 11*(3+1)=44 cycles
    divider = 8'd3; enable = 1'b1;
    @(posedge clk); #1;
    lowRun = 0;
    while (sclDriveLow && lowRun < 200) begin lowRun++; @(posedge clk); #1; end
    checks++;
    if (lowRun != 44) begin
      fails++;
      $display("FAIL R2 R5 low run: actual %0d expected %0d", lowRun, 44);
    end
    runCycles(40);
    enable = 1'b0; runCycles(2);

    curReq = "R6"; ratioSel = 2'd3; divider = 8'd1; enable = 1'b1;
    runCycles(60);
    enable = 1'b0; runCycles(2);

    // R7: slave holds the line during high phases
    curReq = "R7"; ratioSel = 2'd0; divider = 8'd1; enable = 1'b1;
    for (int i = 0; i < 120; i++) begin
      slaveHold = (i % 11 >= 7) || (i >= 30 && i < 42);
      runCycles(1);
    end
    slaveHold = 1'b0;
    runCycles(20);

    // R10: config changes mid-period apply from next low phase
    curReq = "R10";
    for (int i = 0; i < 6; i++) begin
      ratioSel = 2'(i % 3);
      divider  = 8'(i % 4);
      runCycles(13 + 5 * i);
    end
    runCycles(40);

    // R11: disable in the middle of phases, then restart
    curReq = "R11";
    for (int i = 0; i < 4; i++) begin
      runCycles(7 + 3 * i);
      enable = 1'b0;
      runCycles(2);
      enable = 1'b1;
    end
    runCycles(40);
    enable = 1'b0;
    runCycles(4);
    finishRun();
  end

endmodule